// File: doc/BRIEF.md
# DAC Code Up/Down Stepper

This block holds the 12-bit code register of a digital-to-analog converter. It lets a board nudge that code with two pulse pins instead of going through the serial port. A falling edge on the raise pin adds one step to the code, and a falling edge on the lower pin takes one step away. The pins act only while the serial chip-select is idle. A two-bit mode field chooses the step size and therefore the effective resolution: 12, 10 or 8 bits. The code bits below the chosen step position are never touched. A step that would carry out of the top of the field, or borrow below zero, holds the code at that limit instead of wrapping.

The pins are asynchronous to the system clock. They pass through a two-stage synchronizer, and the block detects edges in the clock domain, so the clock must run at least eight times faster than the fastest step rate. The serial side writes the code through a one-cycle load port, and a load wins over a step that lands in the same cycle. An asynchronous clear pin forces the code to zero, but only once the supply-ready flag reports a valid supply.

Top module: `dac_step_top`

## Requirements
- R1: With the chip-select high and the lower pin low, a falling edge on the raise pin adds one step to the code. The new code appears on the third rising clock edge after the pin falls.
- R2: With the chip-select high and the raise pin low, a falling edge on the lower pin subtracts one step from the code, with the same latency as R1.
- R3: An edge on either pin while the other pin is high leaves the code unchanged.
- R4: While the chip-select is low, edges on the pins leave the code unchanged.
- R5: Mode 0 steps by 1 (bit 0), mode 1 steps by 4 (bit 2) and mode 2 steps by 16 (bit 4).
- R6: A step never changes the code bits below the step position: none in mode 0, bits 1:0 in mode 1, bits 3:0 in mode 2.
- R7: A raise when the field at and above the step position is all ones leaves the code unchanged. A lower when that field is all zeros leaves the code unchanged.
- R8: Mode 3 performs no stepping.
- R9: With the ready flag low, a high level on the clear pin forces the code to 000h at once, without waiting for a clock edge.
- R10: With the ready flag high, the clear pin has no effect on the code.
- R11: A load strobe copies the load value into the code on the next rising edge, and takes priority over a step in that same cycle.
- R12: The active-low reset sets the code to 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upPin | input | 1 | Raise pulse pin (asynchronous) |
| downPin | input | 1 | Lower pulse pin (asynchronous) |
| csPin | input | 1 | Serial chip-select; stepping allowed while high |
| clrPin | input | 1 | Asynchronous active-high clear |
| rdyPin | input | 1 | Supply flag; high means supply not yet valid |
| modeSel | input | 2 | Step position select (0: bit 0, 1: bit 2, 2: bit 4, 3: none) |
| loadEn | input | 1 | One-cycle serial load strobe |
| loadCode | input | 12 | Code value written on a load |
| code | output | 12 | Current DAC code |

## Verification
Single valid pulses on each pin, in every mode, separate the three step sizes and show that the low bits survive. Loads of all-ones and all-zeros upper fields check that the code holds at its limit. Pulses sent with the opposite pin high, or with the chip-select low, must leave the code alone. A load timed to meet a step strobe in the same cycle shows which of the two wins. A random mix of pulses, loads, mode changes and blocked pulses is then compared against a bench model of the saturating step.

// File: rtl/dac_step_pkg.sv
package dac_step_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepStb_t;
endpackage

// File: rtl/dac_step_sync.sv
module dac_step_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else begin
      shReg[0] <= din;
      for (int i = 1; i < STAGES; i++) shReg[i] <= shReg[i-1];
    end
  end

  assign dout = shReg[STAGES-1];
endmodule

// File: rtl/dac_step_ctrl.sv
module dac_step_ctrl
  import dac_step_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       upPin,
  input  logic       downPin,
  input  logic       csPin,
  input  logic [1:0] modeSel,
  output stepStb_t   stb
);
  logic [2:0] synced;
  logic upS, downS, csS;
  logic upPrev, downPrev;
  logic upFall, downFall, modeOk;

  dac_step_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({csPin, downPin, upPin}),
    .dout (synced)
  );

  assign upS   = synced[0];
  assign downS = synced[1];
  assign csS   = synced[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upPrev   <= 1'b0;
      downPrev <= 1'b0;
    end else begin
      upPrev   <= upS;
      downPrev <= downS;
    end
  end

  assign upFall   = upPrev & ~upS;
  assign downFall = downPrev & ~downS;
  assign modeOk   = (modeSel != 2'b11);

  // The other pin must stay low before and after the edge
  always_comb begin
    stb.stepUp   = upFall & ~downS & ~downPrev & csS & modeOk;
    stb.stepDown = downFall & ~upS & ~upPrev & csS & modeOk;
  end
endmodule

// File: rtl/dac_step_dp.sv
module dac_step_dp
  import dac_step_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int SHIFT_UNIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrPin,
  input  logic              rdyPin,
  input  logic [1:0]        modeSel,
  input  logic              loadEn,
  input  logic [CODE_W-1:0] loadCode,
  input  stepStb_t          stb,
  output logic [CODE_W-1:0] code
);
  localparam int SHW = $clog2(CODE_W);

  logic [SHW-1:0]    shiftAmt;
  logic [CODE_W-1:0] stepVal, hiMask;
  logic              atTop, atBot, clrAsync;

  assign clrAsync = clrPin & ~rdyPin;

  always_comb begin
    shiftAmt = SHW'(modeSel) * SHW'(SHIFT_UNIT);
    stepVal  = CODE_W'(1) << shiftAmt;
    hiMask   = ~(stepVal - CODE_W'(1));
    atTop    = ((code & hiMask) == hiMask);
    atBot    = ((code & hiMask) == '0);
  end

  always_ff @(posedge clk or negedge rstN or posedge clrAsync) begin
    if (!rstN)                        code <= '0;
    else if (clrAsync)                code <= '0;
    else if (loadEn)                  code <= loadCode;
    else if (stb.stepUp && !atTop)    code <= code + stepVal;
    else if (stb.stepDown && !atBot)  code <= code - stepVal;
  end
endmodule

// File: rtl/dac_step_top.sv
module dac_step_top
  import dac_step_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int SHIFT_UNIT  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upPin,
  input  logic              downPin,
  input  logic              csPin,
  input  logic              clrPin,
  input  logic              rdyPin,
  input  logic [1:0]        modeSel,
  input  logic              loadEn,
  input  logic [CODE_W-1:0] loadCode,
  output logic [CODE_W-1:0] code
);
  stepStb_t stb;

  dac_step_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .upPin   (upPin),
    .downPin (downPin),
    .csPin   (csPin),
    .modeSel (modeSel),
    .stb     (stb)
  );

  dac_step_dp #(.CODE_W(CODE_W), .SHIFT_UNIT(SHIFT_UNIT)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .clrPin   (clrPin),
    .rdyPin   (rdyPin),
    .modeSel  (modeSel),
    .loadEn   (loadEn),
    .loadCode (loadCode),
    .stb      (stb),
    .code     (code)
  );
endmodule

// File: rtl/dac_step_chk.sv
module dac_step_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              clrPin,
  input logic              rdyPin,
  input logic [1:0]        modeSel,
  input logic              loadEn,
  input logic [CODE_W-1:0] loadCode,
  input logic [CODE_W-1:0] code,
  input logic              stepUp,
  input logic              stepDown
);
  logic              clrEff;
  logic [CODE_W-1:0] incr, lowMask;

  assign clrEff = clrPin & ~rdyPin;

  always_comb begin
    case (modeSel)
      2'd1:    incr = CODE_W'(4);
      2'd2:    incr = CODE_W'(16);
      default: incr = CODE_W'(1);
    endcase
    lowMask = incr - CODE_W'(1);
  end

  // R1: a raise strobe below the limit adds one step
  a_r1_inc_step: assert property (@(posedge clk) disable iff (!rstN || clrEff)
    stepUp && !loadEn && ((code | lowMask) != '1) |=> code == $past(code) + $past(incr));

  // R2: a lower strobe above zero subtracts one step
  a_r2_dec_step: assert property (@(posedge clk) disable iff (!rstN || clrEff)
    stepDown && !loadEn && ((code & ~lowMask) != '0) |=> code == $past(code) - $past(incr));

  // R3: never both directions at once
  a_r3_one_dir: assert property (@(posedge clk) disable iff (!rstN)
    !(stepUp && stepDown));

  // R6: bits below the step position are kept
  a_r6_low_kept: assert property (@(posedge clk) disable iff (!rstN || clrEff)
    (stepUp || stepDown) && !loadEn |=> ((code ^ $past(code)) & $past(lowMask)) == '0);

  // R7: a raise at all-ones holds
  a_r7_sat_top: assert property (@(posedge clk) disable iff (!rstN || clrEff)
    stepUp && !loadEn && (code == '1) |=> code == '1);

  // R8: mode 3 raises no strobe
  a_r8_mode_idle: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b11) |-> !stepUp && !stepDown);

  // R9: code is zero while the clear is in force
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clrEff |-> code == '0);

  // R11: a load wins
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rstN || clrEff)
    loadEn |=> code == $past(loadCode));
endmodule

bind dac_step_top dac_step_chk #(.CODE_W(CODE_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .clrPin   (clrPin),
  .rdyPin   (rdyPin),
  .modeSel  (modeSel),
  .loadEn   (loadEn),
  .loadCode (loadCode),
  .code     (code),
  .stepUp   (stb.stepUp),
  .stepDown (stb.stepDown)
);

// File: tb/tb_dac_step_top.sv
module tb_dac_step_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        upPin = 1'b0, downPin = 1'b0, csPin = 1'b1;
  logic        clrPin = 1'b0, rdyPin = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic        loadEn = 1'b0;
  logic [11:0] loadCode = 12'h000;
  logic [11:0] code;
  logic [11:0] expCode;
  int vecs = 0, errs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_step_top dut (
    .clk(clk), .rstN(rstN), .upPin(upPin), .downPin(downPin), .csPin(csPin),
    .clrPin(clrPin), .rdyPin(rdyPin), .modeSel(modeSel), .loadEn(loadEn),
    .loadCode(loadCode), .code(code)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: code=%03h expected %03h", req, got, exp);
    end
  endtask

  function automatic logic [11:0] model(input logic [11:0] c, input logic [1:0] m, input bit up);
    logic [11:0] st, hi;
    if (m == 2'd3) return c;
    st = 12'd1 << (m * 2);
    hi = ~(st - 12'd1);
    if (up) return ((c & hi) == hi) ? c : c + st;
    else    return ((c & hi) == 12'd0) ? c : c - st;
  endfunction

  task automatic pulseUp();
    upPin = 1'b1; tick(4); upPin = 1'b0; tick(5);
  endtask

  task automatic pulseDown();
    downPin = 1'b1; tick(4); downPin = 1'b0; tick(5);
  endtask

  task automatic doLoad(input logic [11:0] v);
    loadCode = v; loadEn = 1'b1; tick(1); loadEn = 1'b0; tick(1);
  endtask

  task automatic setMode(input logic [1:0] m);
    modeSel = m; tick(3);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++;
      vecs++;
      $display("FAIL watchdog: run hung");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    check("R12 reset", code, 12'h000);
    rstN = 1'b1;
    tick(4);

    // R11 and R1, R2 in mode 0
    doLoad(12'h123);  check("R11 load", code, 12'h123);
    pulseUp();        check("R1 raise", code, 12'h124);
    pulseDown();      check("R2 lower", code, 12'h123);

    // R5 and R6 step positions
    setMode(2'd1); doLoad(12'h7F3); pulseUp();
    check("R5 R6 mode1 raise", code, 12'h7F7);
    setMode(2'd2); doLoad(12'h5A7); pulseDown();
    check("R5 R6 mode2 lower", code, 12'h597);

    // R7 saturation
    setMode(2'd0); doLoad(12'hFFF); pulseUp();
    check("R7 top mode0", code, 12'hFFF);
    setMode(2'd2); doLoad(12'hFF5); pulseUp();
    check("R7 top mode2", code, 12'hFF5);
    setMode(2'd1); doLoad(12'h002); pulseDown();
    check("R7 bottom mode1", code, 12'h002);

    // R8 mode 3
    setMode(2'd3); doLoad(12'h100); pulseUp(); pulseDown();
    check("R8 mode3", code, 12'h100);

    // R3 invalid: raise edge while lower pin high
    setMode(2'd0); doLoad(12'h400);
    downPin = 1'b1; tick(4); pulseUp();
    check("R3 invalid combo", code, 12'h400);
    csPin = 1'b0; tick(4); downPin = 1'b0; tick(5); csPin = 1'b1; tick(4);
    check("R3 release", code, 12'h400);

    // R4 chip-select low blocks stepping
    csPin = 1'b0; tick(4); pulseUp(); pulseDown();
    check("R4 cs low", code, 12'h400);
    csPin = 1'b1; tick(4);

    // R9 async clear
    doLoad(12'hABC);
    clrPin = 1'b1; #1;
    check("R9 async clear", code, 12'h000);
    tick(2); clrPin = 1'b0; tick(1);

    // R10 clear ignored while ready flag high
    doLoad(12'hABC);
    rdyPin = 1'b1; tick(1); clrPin = 1'b1; #1;
    check("R10 clear ignored", code, 12'hABC);
    tick(3); clrPin = 1'b0; tick(1); rdyPin = 1'b0; tick(1);
    check("R10 after", code, 12'hABC);

    // R11 load collides with step strobe
    doLoad(12'h200);
    upPin = 1'b1; tick(4); upPin = 1'b0; tick(2);
    loadCode = 12'h055; loadEn = 1'b1; tick(1); loadEn = 1'b0;
    check("R11 load priority", code, 12'h055);
    tick(4);
    check("R11 no late step", code, 12'h055);

    // Random mix against model
    expCode = code;
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: begin pulseUp();   expCode = model(expCode, modeSel, 1'b1);
                 check("R1 R5 R6 R7 random raise", code, expCode); end
        1: begin pulseDown(); expCode = model(expCode, modeSel, 1'b0);
                 check("R2 R5 R6 R7 random lower", code, expCode); end
        2: begin
             logic [11:0] v;
             v = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) == 1) ? 12'hFFF : 12'h000)
                                              : 12'($urandom());
             doLoad(v); expCode = v;
             check("R11 random load", code, expCode);
           end
        3: begin setMode(2'($urandom_range(0, 3)));
                 check("R8 random mode", code, expCode); end
        default: begin
             csPin = 1'b0; tick(4);
             if ($urandom_range(0, 1) == 1) pulseUp(); else pulseDown();
             csPin = 1'b1; tick(4);
             check("R4 random cs low", code, expCode);
           end
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule